// File: doc/BRIEF.md
# Byte-Framed Serial Control Receiver

This block is the write-only control port of a multi-register audio settings controller. A host drives three lines: an active-low frame enable, a serial clock and a serial data line. While the enable is low, each rising edge of the serial clock shifts one data bit into an 8-bit shift register, most significant bit first. When the enable returns high, the byte is written into the one setting register its leading bits select. The write happens only if exactly eight serial clock edges arrived while the enable was low. Frames with too few or too many edges, including those caused by glitches on the clock line, change nothing.

All three serial inputs are sampled by the block's own system clock through a two-stage synchronizer. A serial clock rising edge is found by comparing the synchronized level with its value one cycle earlier. The frame is tracked by a three-state machine. ST_IDLE holds the bit counter and shift register clear while the enable is high. The transition idle-to-shift is taken when the synchronized enable is seen low. ST_SHIFT counts and shifts serial clock edges. When the enable rises there, the transition shift-to-commit is taken if the count is exactly eight, and the transition shift-to-idle (discard) is taken for any other count. ST_COMMIT lasts one cycle and writes the byte. Its transition commit-to-idle is unconditional.

The outputs are the held settings: a two-field volume attenuation, bass and treble codes, four speaker attenuators, and an input selector whose top code means muted. A combined full-mute flag is also output. An asynchronous reset restores the power-on values.

Top module: `serial_ctrl_rx`

## Requirements
- R1: After `rst_n` is asserted (low, asynchronous), the outputs take their power-on values: `vol_coarse`=7 and `vol_fine`=7 (the largest attenuation, -78.75 dB), every 5-bit field of `spk_att`=31 (muted), `in_sel`=7 (muted), `bass_code`=0 (-20 dB), `treble_code`=0 (-14 dB) and `full_mute`=1.
- R2: While `ctl_en_n` is low, every rising edge of `ctl_sclk` shifts `ctl_sdata` in, most significant bit first. The rising edge of `ctl_en_n` then writes the received byte into the register that the byte selects.
- R3: A frame in which the number of `ctl_sclk` rising edges is not exactly 8 (for example 0, 1, 3, 7, 9, 16 or 300) leaves every output unchanged. The edge count saturates at 9, so a long frame can never wrap around to 8. The count restarts at zero for every frame.
- R4: The outputs change only when a valid frame is committed, never while a frame is still being received.
- R5: A byte `00cccfff` sets `vol_coarse`=ccc (10 dB steps) and `vol_fine`=fff (1.25 dB steps).
- R6: A byte `1ssaaaaa` sets speaker attenuator ss (0 to 3), which is the field `spk_att[5*ss+4:5*ss]`, to aaaaa. The code 31 means muted.
- R7: A byte `01000ddd` sets `in_sel`=ddd. The code 7 means the mute input.
- R8: A byte `0110bbbb` sets `bass_code`=bbbb. A byte `0111tttt` sets `treble_code`=tttt.
- R9: Bytes whose prefix is `01001` or `0101` select no register and leave every output unchanged.
- R10: `full_mute` is 1 exactly when all four speaker attenuators hold 31 and `in_sel` holds 7.
- R11: `ctl_sclk` edges that occur while `ctl_en_n` is high are not counted toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_en_n | input | 1 | Frame enable, active low |
| ctl_sclk | input | 1 | Serial bit clock |
| ctl_sdata | input | 1 | Serial data, MSB first |
| vol_coarse | output | 3 | Volume attenuation in 10 dB steps |
| vol_fine | output | 3 | Volume attenuation in 1.25 dB steps |
| bass_code | output | 4 | Bass setting code |
| treble_code | output | 4 | Treble setting code |
| spk_att | output | 20 | Four 5-bit speaker attenuators, speaker 0 in bits 4:0 |
| in_sel | output | 3 | Input selector, 7 = muted |
| full_mute | output | 1 | All speakers and the input selector muted |

## Verification
Every field of every register is swept exhaustively: all 64 volume bytes, all 128 speaker bytes, all 8 selector bytes and all 16 codes each for bass and treble. This separates bit-order and field-position errors, and a wrong speaker index shows up as a neighbour changing. All 24 unused-prefix bytes are sent after non-default settings, which distinguishes a decode that ignores them from one that falls through to a real register. Frames with 0, 1, 3, 7, 9, 16 and 300 edges, and serial clock toggling with the enable high, each separate an exact-count gate from an at-least-eight gate, a wrapping counter or a counter that is not cleared. Sequences that mute the speakers and the selector one at a time show when the full-mute flag sets and clears.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int BYTE_W    = 8;
    localparam int VOL_FLD_W = 3;
    localparam int NUM_SPK   = 4;
    localparam int SPK_W     = 5;
    localparam int SEL_W     = 3;
    localparam int TONE_W    = 4;
    localparam int SPK_IDX_W = $clog2(NUM_SPK);

    localparam logic [SPK_W-1:0]     SPK_MUTE    = '1;
    localparam logic [SEL_W-1:0]     SEL_MUTE    = '1;
    localparam logic [VOL_FLD_W-1:0] VOL_MAX_ATT = '1;
    localparam logic [TONE_W-1:0]    TONE_MIN    = '0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT
    } rx_state_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_VOL,
        TGT_SPK,
        TGT_SEL,
        TGT_BASS,
        TGT_TREB
    } target_e;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sc_shift.sv
module sc_shift #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              din,
    output logic [BYTE_W-1:0] byte_q,
    output logic [CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(BYTE_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            byte_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            byte_q <= {byte_q[BYTE_W-2:0], din};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sc_regs.sv
module sc_regs
    import sc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [BYTE_W-1:0]        byte_i,
    output logic [VOL_FLD_W-1:0]     vol_coarse,
    output logic [VOL_FLD_W-1:0]     vol_fine,
    output logic [TONE_W-1:0]        bass_code,
    output logic [TONE_W-1:0]        treble_code,
    output logic [NUM_SPK*SPK_W-1:0] spk_att,
    output logic [SEL_W-1:0]         in_sel,
    output logic                     full_mute
);
    target_e tgt;

    // Prefix decode: 1xxxxxxx speaker, 00xxxxxx volume, 0110 bass,
    // 0111 treble, 01000 selector; 01001 and 0101 are unused.
    always_comb begin
        tgt = TGT_NONE;
        if (byte_i[7])                 tgt = TGT_SPK;
        else if (!byte_i[6])           tgt = TGT_VOL;
        else if (byte_i[5:4] == 2'b10) tgt = TGT_BASS;
        else if (byte_i[5:4] == 2'b11) tgt = TGT_TREB;
        else if (byte_i[5:3] == 3'b000) tgt = TGT_SEL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_coarse  <= VOL_MAX_ATT;
            vol_fine    <= VOL_MAX_ATT;
            bass_code   <= TONE_MIN;
            treble_code <= TONE_MIN;
            in_sel      <= SEL_MUTE;
        end else if (wr) begin
            unique case (tgt)
                TGT_VOL: begin
                    vol_coarse <= byte_i[2*VOL_FLD_W-1:VOL_FLD_W];
                    vol_fine   <= byte_i[VOL_FLD_W-1:0];
                end
                TGT_BASS: bass_code   <= byte_i[TONE_W-1:0];
                TGT_TREB: treble_code <= byte_i[TONE_W-1:0];
                TGT_SEL:  in_sel      <= byte_i[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_SPK; k++) begin : g_spk
        logic [SPK_W-1:0] att_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                att_q <= SPK_MUTE;
            else if (wr && tgt == TGT_SPK &&
                     byte_i[SPK_W+SPK_IDX_W-1:SPK_W] == SPK_IDX_W'(k))
                att_q <= byte_i[SPK_W-1:0];
        end
        assign spk_att[k*SPK_W +: SPK_W] = att_q;
    end

    always_comb begin
        full_mute = (in_sel == SEL_MUTE);
        for (int k = 0; k < NUM_SPK; k++)
            if (spk_att[k*SPK_W +: SPK_W] != SPK_MUTE) full_mute = 1'b0;
    end
endmodule

// File: rtl/serial_ctrl_rx.sv
module serial_ctrl_rx
    import sc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_en_n,
    input  logic                     ctl_sclk,
    input  logic                     ctl_sdata,
    output logic [VOL_FLD_W-1:0]     vol_coarse,
    output logic [VOL_FLD_W-1:0]     vol_fine,
    output logic [TONE_W-1:0]        bass_code,
    output logic [TONE_W-1:0]        treble_code,
    output logic [NUM_SPK*SPK_W-1:0] spk_att,
    output logic [SEL_W-1:0]         in_sel,
    output logic                     full_mute
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    logic              en_s, sclk_s, sdata_s, sclk_prev;
    logic              sclk_rise, clr, step, commit;
    logic [BYTE_W-1:0] frame_byte;
    logic [CNT_W-1:0]  bit_cnt;
    rx_state_e         state_q, state_d;

    sc_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ctl_en_n, ctl_sclk, ctl_sdata}),
        .dout ({en_s, sclk_s, sdata_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end
    assign sclk_rise = sclk_s && !sclk_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!en_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (en_s) state_d = (bit_cnt == CNT_FULL) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        clr    = (state_q == ST_IDLE);
        step   = (state_q == ST_SHIFT) && sclk_rise && !en_s;
        commit = (state_q == ST_COMMIT);
    end

    sc_shift #(
        .BYTE_W(BYTE_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (step),
        .din   (sdata_s),
        .byte_q(frame_byte),
        .cnt_q (bit_cnt)
    );

    sc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (commit),
        .byte_i     (frame_byte),
        .vol_coarse (vol_coarse),
        .vol_fine   (vol_fine),
        .bass_code  (bass_code),
        .treble_code(treble_code),
        .spk_att    (spk_att),
        .in_sel     (in_sel),
        .full_mute  (full_mute)
    );
endmodule

// File: rtl/sc_rx_checks.sv
module sc_rx_checks
    import sc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     commit,
    input logic [CNT_W-1:0]         bit_cnt,
    input logic [BYTE_W-1:0]        frame_byte,
    input logic [VOL_FLD_W-1:0]     vol_coarse,
    input logic [VOL_FLD_W-1:0]     vol_fine,
    input logic [TONE_W-1:0]        bass_code,
    input logic [TONE_W-1:0]        treble_code,
    input logic [NUM_SPK*SPK_W-1:0] spk_att,
    input logic [SEL_W-1:0]         in_sel
);
    logic [2*VOL_FLD_W+2*TONE_W+NUM_SPK*SPK_W+SEL_W-1:0] all_regs;
    logic unused_prefix;

    assign all_regs = {vol_coarse, vol_fine, bass_code, treble_code, spk_att, in_sel};
    assign unused_prefix = (frame_byte[7:6] == 2'b01) &&
                           ((frame_byte[5:4] == 2'b01) || (frame_byte[5:3] == 3'b001));

    p_commit_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> bit_cnt == CNT_W'(BYTE_W));

    p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W + 1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(all_regs));

    p_commit_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && unused_prefix) |=> $stable(all_regs));
endmodule

bind serial_ctrl_rx sc_rx_checks #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .bit_cnt    (bit_cnt),
    .frame_byte (frame_byte),
    .vol_coarse (vol_coarse),
    .vol_fine   (vol_fine),
    .bass_code  (bass_code),
    .treble_code(treble_code),
    .spk_att    (spk_att),
    .in_sel     (in_sel)
);

// File: tb/serial_ctrl_rx_bench.sv
module serial_ctrl_rx_bench;
    localparam int H = 4;

    logic clk = 1'b0, rst_n = 1'b0, en_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
    logic [2:0]  vol_coarse, vol_fine, in_sel;
    logic [3:0]  bass_code, treble_code;
    logic [19:0] spk_att;
    logic        full_mute;

    logic [2:0]  e_vc, e_vf, e_sel;
    logic [3:0]  e_bass, e_treb;
    logic [19:0] e_spk;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_ctrl_rx u_serial_ctrl_rx (
        .clk(clk), .rst_n(rst_n), .ctl_en_n(en_n), .ctl_sclk(sclk), .ctl_sdata(sdat),
        .vol_coarse(vol_coarse), .vol_fine(vol_fine), .bass_code(bass_code),
        .treble_code(treble_code), .spk_att(spk_att), .in_sel(in_sel),
        .full_mute(full_mute)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic por_expect();
        e_vc = 3'd7; e_vf = 3'd7; e_spk = {4{5'd31}}; e_sel = 3'd7;
        e_bass = 4'd0; e_treb = 4'd0;
    endtask

    task automatic model(input logic [7:0] b);
        if (b[7])                    e_spk[32'(b[6:5])*5 +: 5] = b[4:0];
        else if (!b[6])              begin e_vc = b[5:3]; e_vf = b[2:0]; end
        else if (b[5:4] == 2'b10)    e_bass = b[3:0];
        else if (b[5:4] == 2'b11)    e_treb = b[3:0];
        else if (b[5:3] == 3'b000)   e_sel = b[2:0];
    endtask

    task automatic check_all(input string tag);
        logic e_mute;
        e_mute = (e_spk == {4{5'd31}}) && (e_sel == 3'd7);
        checks++;
        if ({vol_coarse, vol_fine, spk_att, in_sel, bass_code, treble_code, full_mute} !==
            {e_vc, e_vf, e_spk, e_sel, e_bass, e_treb, e_mute}) begin
            errors++;
            $display("FAIL %s: got vol=%0d/%0d spk=%h sel=%0d bass=%0d treb=%0d mute=%0b expected vol=%0d/%0d spk=%h sel=%0d bass=%0d treb=%0d mute=%0b",
                     tag, vol_coarse, vol_fine, spk_att, in_sel, bass_code, treble_code, full_mute,
                     e_vc, e_vf, e_spk, e_sel, e_bass, e_treb, e_mute);
        end
    endtask

    task automatic send(input logic [7:0] b, input int nclk, input string tag, input bit mid);
        en_n = 1'b0;
        wait_cyc(H);
        for (int i = 0; i < nclk; i++) begin
            sdat = b[7 - (i % 8)];
            wait_cyc(H);
            sclk = 1'b1;
            wait_cyc(H);
            sclk = 1'b0;
        end
        wait_cyc(H);
        if (mid) check_all({tag, " mid-frame R4"});
        en_n = 1'b1;
        wait_cyc(10);
        if (nclk == 8) model(b);
        check_all(tag);
    endtask

    initial begin
        por_expect();
        wait_cyc(5);
        check_all("R1 in reset");
        rst_n = 1'b1;
        wait_cyc(5);
        check_all("R1 after reset");

        for (int v = 0; v < 64; v++) send({2'b00, 6'(v)}, 8, "R2 R5 volume", v == 5);
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 32; a++) send({1'b1, 2'(s), 5'(a)}, 8, "R6 speaker", a == 9);
        for (int d = 0; d < 8; d++) send({5'b01000, 3'(d)}, 8, "R7 selector", 1'b0);
        for (int t = 0; t < 16; t++) send({4'b0110, 4'(t)}, 8, "R8 bass", 1'b0);
        for (int t = 0; t < 16; t++) send({4'b0111, 4'(t)}, 8, "R8 treble", 1'b0);

        send(8'h12, 8, "R10 setup", 1'b0);
        send(8'hA3, 8, "R10 one speaker unmuted", 1'b0);
        send(8'hBF, 8, "R10 speakers muted again", 1'b0);
        send(8'h42, 8, "R10 selector unmuted", 1'b0);
        send(8'h47, 8, "R10 full mute restored", 1'b0);
        send(8'h65, 8, "R9 setup bass", 1'b0);
        send(8'h73, 8, "R9 setup treble", 1'b0);
        send(8'h44, 8, "R9 setup selector", 1'b0);

        for (int k = 0; k < 8; k++)  send({5'b01001, 3'(k)}, 8, "R9 prefix 01001", 1'b0);
        for (int k = 0; k < 16; k++) send({4'b0101, 4'(k)}, 8, "R9 prefix 0101", 1'b0);

        send(8'h00, 0,   "R3 zero edges", 1'b0);
        send(8'h00, 1,   "R3 one edge", 1'b0);
        send(8'h00, 7,   "R3 seven edges", 1'b0);
        send(8'h00, 9,   "R3 nine edges", 1'b0);
        send(8'h00, 16,  "R3 sixteen edges", 1'b0);
        send(8'h00, 300, "R3 saturation 300 edges", 1'b0);
        send(8'h00, 3,   "R3 short frame", 1'b0);
        send(8'h2D, 8,   "R3 count restarts", 1'b0);

        for (int i = 0; i < 5; i++) begin
            wait_cyc(H); sclk = 1'b1; wait_cyc(H); sclk = 1'b0;
        end
        send(8'h1B, 8, "R11 edges with enable high", 1'b0);

        rst_n = 1'b0;
        wait_cyc(3);
        por_expect();
        check_all("R1 reset after writes");
        rst_n = 1'b1;
        wait_cyc(5);
        check_all("R1 released");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule